// File: doc/BRIEF.md
# Cipher Engine Control Register

This block is the 32-bit control word of a block-cipher accelerator, reached over a simple register bus. The bus has a select, a write strobe and a read strobe, and every access covers the full word. The register holds the engine configuration: enable, data-swap type, operating mode, a 3-bit chaining mode, key size, authenticated-mode phase and padding-byte count. It also holds the interrupt and DMA enables. Two write-only strobe bits clear the completion flag and the error flags.

The block enforces the rules that keep a running engine consistent:
- The cipher configuration fields are frozen while the engine is enabled.
- A request to derive the key and then decrypt is reduced to a plain decrypt when the chaining mode cannot support it.
- A plain decrypt cannot replace a derive-then-decrypt setting.
- Enable drops by itself when key preparation or the authenticated-mode init phase completes.
- Each rising edge of enable emits a one-cycle re-initialisation pulse.

The status flags and the datapath's DMA wishes arrive as inputs. From them the block forms the interrupt line and the gated DMA requests.

Top module: `cipher_ctrl_reg`

Word layout (bit positions), used by the requirements below:

| Bits | Field |
|------|-------|
| 0 | enable |
| 1 | completion-interrupt enable |
| 2 | error-interrupt enable |
| 3 | input-DMA enable |
| 4 | output-DMA enable |
| 6:5 | phase (0 init, 1 header, 2 payload, 3 final) |
| 7 | chaining mode bit 2 |
| 9:8 | chaining mode bits 1:0 |
| 11:10 | mode |
| 13:12 | swap type |
| 14 | key size (0 = 128, 1 = 256) |
| 19:16 | padding count |
| 24 | completion-clear strobe |
| 25 | error-clear strobe |

Encodings:
- Mode: 0 encrypt, 1 key derivation, 2 decrypt, 3 derive then decrypt.
- Chaining: 0 ECB, 1 CBC, 2 CTR, 3 GCM/GMAC, 4 CCM, 5 to 7 reserved.

## Requirements
- R1: After reset every field is 0, a read returns 0, and the outputs enable, reinit, irq and both DMA requests are 0.
- R2: A write accepted with enable low stores every field at its position in the layout above. A read (select and read high) returns the stored word combinationally, with bits 24 and 25 reading 0.
- R3: When enable is 1 before a write and that write keeps bit 0 at 1, the swap, mode, chaining and key-size fields keep their values. The interrupt enables, DMA enables, phase and padding fields are still written.
- R4: An accepted write that requests mode 3 with a chaining value other than 0 or 1 (the value in the same write) stores mode 2.
- R5: An accepted write that requests mode 2 while the stored mode is 3 leaves the mode at 3.
- R6: reinit_o is high for exactly the first cycle in which enable reads 1 after having been 0.
- R7: Enable clears in the cycle after keyprep_done while enabled with mode 1. It also clears in the cycle after init_done while enabled with chaining 3 or 4 and phase 0. Neither event clears it otherwise, and a hardware clear wins over a concurrent bus write of bit 0.
- R8: During a write cycle, clr_ccf_o equals bit 24 and clr_err_o equals bit 25. clr_err_o is the single strobe that clears both the read-error and the write-error flags. Neither strobe is high without a write.
- R9: dma_in_req = dma_in_pending AND bit 3 AND (mode is 0 or 2), and the same form holds for dma_out_req with bit 4. Both are 0 in modes 1 and 3.
- R10: irq_o = (flag_ccf AND bit 1) OR ((flag_rderr OR flag_wrerr) AND bit 2).
- R11: phase_valid is 1 exactly when the stored chaining value is 3 or 4.
- R12: reserved_cfg is 1 exactly when the stored chaining value is 5, 6 or 7. Such values are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| keyprep_done | input | 1 | Key preparation completed |
| init_done | input | 1 | Authenticated-mode init phase completed |
| flag_ccf | input | 1 | Completion flag |
| flag_rderr | input | 1 | Read-error flag |
| flag_wrerr | input | 1 | Write-error flag |
| dma_in_pending | input | 1 | Datapath wants input data |
| dma_out_pending | input | 1 | Datapath has output data |
| cfg_en | output | 1 | Engine enable |
| cfg_swap | output | 2 | Data-swap type |
| cfg_mode | output | 2 | Effective operating mode |
| cfg_chain | output | 3 | Chaining mode |
| cfg_keysize | output | 1 | Key size select |
| cfg_phase | output | 2 | Authenticated-mode phase |
| cfg_pad | output | 4 | Padding-byte count |
| phase_valid | output | 1 | Phase field is meaningful |
| reserved_cfg | output | 1 | Chaining value is reserved |
| reinit_o | output | 1 | Re-initialisation pulse |
| clr_ccf_o | output | 1 | Completion-flag clear strobe |
| clr_err_o | output | 1 | Error-flags clear strobe |
| irq_o | output | 1 | Interrupt request |
| dma_in_req | output | 1 | Gated input DMA request |
| dma_out_req | output | 1 | Gated output DMA request |

## Verification
The bench sweeps every requested mode against every chaining value and every prior mode. This exposes a design that coerces mode 3 using the old chaining value instead of the one in the same write, and a design that lets mode 2 overwrite mode 3. It writes new configuration both with enable kept high and with enable dropped in the same write. A wrong lock would either freeze the free fields or let the key size and mode change under a running engine. It pulses the completion events in matching and non-matching modes and phases, which catches an enable that self-clears on the wrong event. Finally, it sweeps the flag, enable and mode inputs to the interrupt and DMA gates, which finds a request leaking out in key-derivation mode or an interrupt ignoring its mask.

// File: rtl/cipher_ctrl_pkg.sv
package cipher_ctrl_pkg;

    localparam int WORD_W     = 32;
    localparam int SWAP_W     = 2;
    localparam int MODE_W     = 2;
    localparam int CHAIN_W    = 3;
    localparam int CHLO_W     = 2;
    localparam int PHASE_W    = 2;
    localparam int PAD_W      = 4;

    localparam int EN_BIT     = 0;
    localparam int CCFIE_BIT  = 1;
    localparam int ERRIE_BIT  = 2;
    localparam int DIN_BIT    = 3;
    localparam int DOUT_BIT   = 4;
    localparam int PHASE_LSB  = 5;
    localparam int CHHI_BIT   = 7;
    localparam int CHLO_LSB   = 8;
    localparam int MODE_LSB   = 10;
    localparam int SWAP_LSB   = 12;
    localparam int KEY_BIT    = 14;
    localparam int PAD_LSB    = 16;
    localparam int CCFCLR_BIT = 24;
    localparam int ERRCLR_BIT = 25;

    localparam logic [CHAIN_W-1:0] CH_ECB = 3'd0;
    localparam logic [CHAIN_W-1:0] CH_CBC = 3'd1;
    localparam logic [CHAIN_W-1:0] CH_GCM = 3'd3;
    localparam logic [CHAIN_W-1:0] CH_CCM = 3'd4;
    localparam logic [PHASE_W-1:0] PH_INIT = 2'd0;

    typedef enum logic [MODE_W-1:0] {
        MODE_ENC        = 2'd0,
        MODE_KEYDER     = 2'd1,
        MODE_DEC        = 2'd2,
        MODE_KEYDER_DEC = 2'd3
    } op_mode_e;

    typedef struct packed {
        logic [SWAP_W-1:0]  swap;
        op_mode_e           mode;
        logic [CHAIN_W-1:0] chain;
        logic               keysize;
    } locked_cfg_t;

    typedef struct packed {
        logic               ccf_ie;
        logic               err_ie;
        logic               din_en;
        logic               dout_en;
        logic [PHASE_W-1:0] phase;
        logic [PAD_W-1:0]   pad;
    } free_cfg_t;

    function automatic logic is_auth_chain(input logic [CHAIN_W-1:0] c);
        return (c == CH_GCM) || (c == CH_CCM);
    endfunction

    function automatic logic is_reserved_chain(input logic [CHAIN_W-1:0] c);
        return c > CH_CCM;
    endfunction

    function automatic op_mode_e resolve_mode(input op_mode_e req,
                                              input op_mode_e cur,
                                              input logic [CHAIN_W-1:0] chain);
        op_mode_e m;
        m = req;
        if (req == MODE_KEYDER_DEC && chain != CH_ECB && chain != CH_CBC)
            m = MODE_DEC;
        if (req == MODE_DEC && cur == MODE_KEYDER_DEC)
            m = MODE_KEYDER_DEC;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic en,
                                                    input locked_cfg_t l,
                                                    input free_cfg_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EN_BIT]                      = en;
        w[CCFIE_BIT]                   = f.ccf_ie;
        w[ERRIE_BIT]                   = f.err_ie;
        w[DIN_BIT]                     = f.din_en;
        w[DOUT_BIT]                    = f.dout_en;
        w[PHASE_LSB +: PHASE_W]        = f.phase;
        w[CHHI_BIT]                    = l.chain[CHAIN_W-1];
        w[CHLO_LSB +: CHLO_W]          = l.chain[CHLO_W-1:0];
        w[MODE_LSB +: MODE_W]          = l.mode;
        w[SWAP_LSB +: SWAP_W]          = l.swap;
        w[KEY_BIT]                     = l.keysize;
        w[PAD_LSB +: PAD_W]            = f.pad;
        return w;
    endfunction

endpackage

// File: rtl/ccr_lock_store.sv
module ccr_lock_store
    import cipher_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic        wr_en_bit,
    input  logic        en_q,
    input  locked_cfg_t wr_cfg,
    output locked_cfg_t cfg_q
);
    logic        accept;
    locked_cfg_t cfg_d;

    always_comb begin
        accept     = wr_hit && !(en_q && wr_en_bit);
        cfg_d      = cfg_q;
        if (accept) begin
            cfg_d.swap    = wr_cfg.swap;
            cfg_d.chain   = wr_cfg.chain;
            cfg_d.keysize = wr_cfg.keysize;
            cfg_d.mode    = resolve_mode(wr_cfg.mode, cfg_q.mode, wr_cfg.chain);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{swap: '0, mode: MODE_ENC, chain: '0, keysize: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/ccr_free_store.sv
module ccr_free_store
    import cipher_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  free_cfg_t wr_cfg,
    output free_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q <= wr_cfg;
        end
    end
endmodule

// File: rtl/ccr_enable_ctl.sv
module ccr_enable_ctl
    import cipher_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_hit,
    input  logic               wr_en_bit,
    input  logic               keyprep_done,
    input  logic               init_done,
    input  op_mode_e           mode,
    input  logic [CHAIN_W-1:0] chain,
    input  logic [PHASE_W-1:0] phase,
    output logic               en_q,
    output logic               reinit
);
    logic en_prev;
    logic auto_clr;
    logic keyprep_hit;
    logic init_hit;

    always_comb begin
        keyprep_hit = keyprep_done && (mode == MODE_KEYDER);
        init_hit    = init_done && is_auth_chain(chain) && (phase == PH_INIT);
        auto_clr    = en_q && (keyprep_hit || init_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            en_prev <= 1'b0;
        end else begin
            en_prev <= en_q;
            if (auto_clr)
                en_q <= 1'b0;
            else if (wr_hit)
                en_q <= wr_en_bit;
        end
    end

    assign reinit = en_q && !en_prev;
endmodule

// File: rtl/ccr_event_gate.sv
module ccr_event_gate
    import cipher_ctrl_pkg::*;
(
    input  op_mode_e  mode,
    input  free_cfg_t fcfg,
    input  logic      wr_hit,
    input  logic      ccf_clr_bit,
    input  logic      err_clr_bit,
    input  logic      flag_ccf,
    input  logic      flag_rderr,
    input  logic      flag_wrerr,
    input  logic      din_pending,
    input  logic      dout_pending,
    output logic      irq,
    output logic      din_req,
    output logic      dout_req,
    output logic      clr_ccf,
    output logic      clr_err
);
    logic dma_mode_ok;

    always_comb begin
        dma_mode_ok = (mode == MODE_ENC) || (mode == MODE_DEC);
        din_req     = din_pending  && fcfg.din_en  && dma_mode_ok;
        dout_req    = dout_pending && fcfg.dout_en && dma_mode_ok;
        irq         = (flag_ccf && fcfg.ccf_ie) ||
                      ((flag_rderr || flag_wrerr) && fcfg.err_ie);
        clr_ccf     = wr_hit && ccf_clr_bit;
        clr_err     = wr_hit && err_clr_bit;
    end
endmodule

// File: rtl/cipher_ctrl_reg.sv
module cipher_ctrl_reg
    import cipher_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                keyprep_done,
    input  logic                init_done,
    input  logic                flag_ccf,
    input  logic                flag_rderr,
    input  logic                flag_wrerr,
    input  logic                dma_in_pending,
    input  logic                dma_out_pending,
    output logic                cfg_en,
    output logic [SWAP_W-1:0]   cfg_swap,
    output logic [MODE_W-1:0]   cfg_mode,
    output logic [CHAIN_W-1:0]  cfg_chain,
    output logic                cfg_keysize,
    output logic [PHASE_W-1:0]  cfg_phase,
    output logic [PAD_W-1:0]    cfg_pad,
    output logic                phase_valid,
    output logic                reserved_cfg,
    output logic                reinit_o,
    output logic                clr_ccf_o,
    output logic                clr_err_o,
    output logic                irq_o,
    output logic                dma_in_req,
    output logic                dma_out_req
);
    logic        wr_hit;
    locked_cfg_t wr_lcfg;
    free_cfg_t   wr_fcfg;
    locked_cfg_t lcfg;
    free_cfg_t   fcfg;
    logic        en_q;
    logic [10:0] unused_wbits;

    assign wr_hit       = bus_sel && bus_wr;
    assign unused_wbits = {bus_wdata[31:26], bus_wdata[23:20], bus_wdata[15]};

    always_comb begin
        wr_lcfg.swap    = bus_wdata[SWAP_LSB +: SWAP_W];
        wr_lcfg.mode    = op_mode_e'(bus_wdata[MODE_LSB +: MODE_W]);
        wr_lcfg.chain   = {bus_wdata[CHHI_BIT], bus_wdata[CHLO_LSB +: CHLO_W]};
        wr_lcfg.keysize = bus_wdata[KEY_BIT];
        wr_fcfg.ccf_ie  = bus_wdata[CCFIE_BIT];
        wr_fcfg.err_ie  = bus_wdata[ERRIE_BIT];
        wr_fcfg.din_en  = bus_wdata[DIN_BIT];
        wr_fcfg.dout_en = bus_wdata[DOUT_BIT];
        wr_fcfg.phase   = bus_wdata[PHASE_LSB +: PHASE_W];
        wr_fcfg.pad     = bus_wdata[PAD_LSB +: PAD_W];
    end

    ccr_lock_store lock_i (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .wr_en_bit (bus_wdata[EN_BIT]),
        .en_q      (en_q),
        .wr_cfg    (wr_lcfg),
        .cfg_q     (lcfg)
    );

    ccr_free_store free_i (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr_cfg (wr_fcfg),
        .cfg_q  (fcfg)
    );

    ccr_enable_ctl enable_i (
        .clk          (clk),
        .rst          (rst),
        .wr_hit       (wr_hit),
        .wr_en_bit    (bus_wdata[EN_BIT]),
        .keyprep_done (keyprep_done),
        .init_done    (init_done),
        .mode         (lcfg.mode),
        .chain        (lcfg.chain),
        .phase        (fcfg.phase),
        .en_q         (en_q),
        .reinit       (reinit_o)
    );

    ccr_event_gate gate_i (
        .mode         (lcfg.mode),
        .fcfg         (fcfg),
        .wr_hit       (wr_hit),
        .ccf_clr_bit  (bus_wdata[CCFCLR_BIT]),
        .err_clr_bit  (bus_wdata[ERRCLR_BIT]),
        .flag_ccf     (flag_ccf),
        .flag_rderr   (flag_rderr),
        .flag_wrerr   (flag_wrerr),
        .din_pending  (dma_in_pending),
        .dout_pending (dma_out_pending),
        .irq          (irq_o),
        .din_req      (dma_in_req),
        .dout_req     (dma_out_req),
        .clr_ccf      (clr_ccf_o),
        .clr_err      (clr_err_o)
    );

    assign bus_rdata    = (bus_sel && bus_rd) ? pack_word(en_q, lcfg, fcfg) : '0;
    assign cfg_en       = en_q;
    assign cfg_swap     = lcfg.swap;
    assign cfg_mode     = lcfg.mode;
    assign cfg_chain    = lcfg.chain;
    assign cfg_keysize  = lcfg.keysize;
    assign cfg_phase    = fcfg.phase;
    assign cfg_pad      = fcfg.pad;
    assign phase_valid  = is_auth_chain(lcfg.chain);
    assign reserved_cfg = is_reserved_chain(lcfg.chain);
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
    import cipher_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic               keyprep_done,
    input logic               flag_ccf,
    input logic               flag_rderr,
    input logic               flag_wrerr,
    input logic               cfg_en,
    input logic [SWAP_W-1:0]  cfg_swap,
    input logic [MODE_W-1:0]  cfg_mode,
    input logic [CHAIN_W-1:0] cfg_chain,
    input logic               cfg_keysize,
    input logic               reinit_o,
    input logic               clr_ccf_o,
    input logic               clr_err_o,
    input logic               irq_o,
    input logic               dma_in_req,
    input logic               dma_out_req
);
    logic               wr_c;
    logic               open_c;
    logic [CHAIN_W-1:0] req_chain;
    logic [MODE_W-1:0]  req_mode;

    assign wr_c      = bus_sel && bus_wr;
    assign open_c    = wr_c && !(cfg_en && bus_wdata[EN_BIT]);
    assign req_chain = {bus_wdata[CHHI_BIT], bus_wdata[CHLO_LSB +: CHLO_W]};
    assign req_mode  = bus_wdata[MODE_LSB +: MODE_W];

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_c && cfg_en && bus_wdata[EN_BIT]) |=>
        ($stable(cfg_mode) && $stable(cfg_chain) && $stable(cfg_swap) && $stable(cfg_keysize)));

    // R4
    mode_coerce_chk: assert property (@(posedge clk) disable iff (rst)
        (open_c && req_mode == 2'd3 && req_chain > 3'd1) |=> (cfg_mode == 2'd2));

    // R5
    mode_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (open_c && req_mode == 2'd2 && cfg_mode == 2'd3) |=> (cfg_mode == 2'd3));

    // R6
    reinit_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_en) |-> reinit_o);

    // R6
    reinit_only_chk: assert property (@(posedge clk) disable iff (rst)
        reinit_o |-> $rose(cfg_en));

    // R7
    keyprep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode == 2'd1 && keyprep_done) |=> !cfg_en);

    // R8
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_ccf_o || clr_err_o) |-> wr_c);

    // R9
    dma_keyder_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'd1) |-> (!dma_in_req && !dma_out_req));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_ccf && !flag_rderr && !flag_wrerr) |-> !irq_o);
endmodule

bind cipher_ctrl_reg ccr_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .keyprep_done (keyprep_done),
    .flag_ccf     (flag_ccf),
    .flag_rderr   (flag_rderr),
    .flag_wrerr   (flag_wrerr),
    .cfg_en       (cfg_en),
    .cfg_swap     (cfg_swap),
    .cfg_mode     (cfg_mode),
    .cfg_chain    (cfg_chain),
    .cfg_keysize  (cfg_keysize),
    .reinit_o     (reinit_o),
    .clr_ccf_o    (clr_ccf_o),
    .clr_err_o    (clr_err_o),
    .irq_o        (irq_o),
    .dma_in_req   (dma_in_req),
    .dma_out_req  (dma_out_req)
);

// File: tb/cipher_ctrl_reg_tb.sv
module cipher_ctrl_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        keyprep_done = 1'b0, init_done = 1'b0;
    logic        flag_ccf = 1'b0, flag_rderr = 1'b0, flag_wrerr = 1'b0;
    logic        dma_in_pending = 1'b0, dma_out_pending = 1'b0;
    logic        cfg_en, cfg_keysize, phase_valid, reserved_cfg, reinit_o;
    logic        clr_ccf_o, clr_err_o, irq_o, dma_in_req, dma_out_req;
    logic [1:0]  cfg_swap, cfg_mode, cfg_phase;
    logic [2:0]  cfg_chain;
    logic [3:0]  cfg_pad;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_ctrl_reg dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .keyprep_done(keyprep_done), .init_done(init_done),
        .flag_ccf(flag_ccf), .flag_rderr(flag_rderr), .flag_wrerr(flag_wrerr),
        .dma_in_pending(dma_in_pending), .dma_out_pending(dma_out_pending),
        .cfg_en(cfg_en), .cfg_swap(cfg_swap), .cfg_mode(cfg_mode), .cfg_chain(cfg_chain),
        .cfg_keysize(cfg_keysize), .cfg_phase(cfg_phase), .cfg_pad(cfg_pad),
        .phase_valid(phase_valid), .reserved_cfg(reserved_cfg), .reinit_o(reinit_o),
        .clr_ccf_o(clr_ccf_o), .clr_err_o(clr_err_o), .irq_o(irq_o),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    function automatic logic [31:0] mk(input logic en, input logic [1:0] swap,
                                       input logic [1:0] mode, input logic [2:0] chain,
                                       input logic ks, input logic [1:0] phase,
                                       input logic [3:0] pad, input logic [3:0] ie_dma);
        logic [31:0] w;
        w        = '0;
        w[0]     = en;
        w[4:1]   = ie_dma;
        w[6:5]   = phase;
        w[7]     = chain[2];
        w[9:8]   = chain[1:0];
        w[11:10] = mode;
        w[13:12] = swap;
        w[14]    = ks;
        w[19:16] = pad;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
        $finish;
    endtask

    task automatic bwrite(input logic [31:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(output logic [31:0] r);
        bus_sel = 1'b1; bus_rd = 1'b1;
        #1;
        r = bus_rdata;
        bus_sel = 1'b0; bus_rd = 1'b0;
        #1;
    endtask

    task automatic pulse_keyprep();
        @(negedge clk); keyprep_done = 1'b1;
        @(negedge clk); keyprep_done = 1'b0;
    endtask

    task automatic pulse_init();
        @(negedge clk); init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] r;
        logic [1:0]  em;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bread(r);
        chk("R1 readback", r, 32'h0);
        chk("R1 outputs", {cfg_en, reinit_o, irq_o, dma_in_req, dma_out_req}, 5'b0);

        // R2 field storage and positions
        bwrite(mk(0, 2'd2, 2'd0, 3'd6, 1, 2'd3, 4'hA, 4'b1010));
        bread(r);
        chk("R2 word A", r, mk(0, 2'd2, 2'd0, 3'd6, 1, 2'd3, 4'hA, 4'b1010));
        chk("R2 ports A", {cfg_swap, cfg_chain, cfg_keysize, cfg_phase, cfg_pad},
            {2'd2, 3'd6, 1'b1, 2'd3, 4'hA});
        // R12 reserved value stored
        chk("R12 reserved flag", reserved_cfg, 1'b1);
        bwrite(mk(0, 2'd1, 2'd1, 3'd2, 0, 2'd1, 4'h5, 4'b0101));
        bread(r);
        chk("R2 word B", r, mk(0, 2'd1, 2'd1, 3'd2, 0, 2'd1, 4'h5, 4'b0101));

        // R4 R5 R11 R12 sweep of mode request, chaining and prior mode
        for (int c = 0; c < 8; c++) begin
            for (int req = 0; req < 4; req++) begin
                for (int pr = 0; pr < 4; pr++) begin
                    bwrite(mk(0, 0, 2'd0, 3'd0, 0, 0, 0, 0));
                    bwrite(mk(0, 0, 2'(pr), 3'd0, 0, 0, 0, 0));
                    bwrite(mk(0, 0, 2'(req), 3'(c), 0, 0, 0, 0));
                    em = 2'(req);
                    if (req == 3 && c > 1) em = 2'd2;
                    if (req == 2 && pr == 3) em = 2'd3;
                    bread(r);
                    chk("R4 R5 mode word", r, mk(0, 0, em, 3'(c), 0, 0, 0, 0));
                    chk("R11 phase_valid", phase_valid, (c == 3 || c == 4));
                    chk("R12 reserved_cfg", reserved_cfg, (c > 4));
                end
            end
        end

        // R6 reinit pulse, R3 lock
        bwrite(mk(0, 0, 2'd0, 3'd0, 0, 0, 0, 0));
        bwrite(mk(1, 2'd1, 2'd0, 3'd1, 1, 2'd0, 4'h5, 4'b0000));
        chk("R6 reinit first cycle", reinit_o, 1'b1);
        @(negedge clk);
        chk("R6 reinit single cycle", reinit_o, 1'b0);
        bwrite(mk(1, 2'd2, 2'd2, 3'd2, 0, 2'd2, 4'h9, 4'b0001));
        bread(r);
        chk("R3 locked keep", r, mk(1, 2'd1, 2'd0, 3'd1, 1, 2'd2, 4'h9, 4'b0001));
        chk("R6 no reinit while held", reinit_o, 1'b0);
        bwrite(mk(0, 2'd3, 2'd2, 3'd2, 0, 2'd0, 4'h9, 4'b0000));
        bread(r);
        chk("R3 unlock on clearing write", r, mk(0, 2'd3, 2'd2, 3'd2, 0, 2'd0, 4'h9, 4'b0000));
        bwrite(mk(1, 2'd3, 2'd2, 3'd2, 0, 2'd0, 4'h9, 4'b0000));
        chk("R6 reinit on re-enable", reinit_o, 1'b1);

        // R7 auto-clear
        bwrite(mk(0, 0, 2'd1, 3'd0, 0, 0, 0, 0));
        bwrite(mk(1, 0, 2'd1, 3'd0, 0, 0, 0, 0));
        pulse_keyprep();
        chk("R7 keyprep clears in mode 1", cfg_en, 1'b0);
        bwrite(mk(1, 0, 2'd0, 3'd0, 0, 0, 0, 0));
        pulse_keyprep();
        chk("R7 keyprep ignored in mode 0", cfg_en, 1'b1);
        pulse_init();
        chk("R7 init ignored in ECB", cfg_en, 1'b1);
        bwrite(mk(0, 0, 2'd0, 3'd3, 0, 2'd0, 0, 0));
        bwrite(mk(1, 0, 2'd0, 3'd3, 0, 2'd0, 0, 0));
        pulse_init();
        chk("R7 init clears GCM phase0", cfg_en, 1'b0);
        bwrite(mk(1, 0, 2'd0, 3'd4, 0, 2'd1, 0, 0));
        pulse_init();
        chk("R7 init ignored phase1", cfg_en, 1'b1);
        bwrite(mk(0, 0, 2'd0, 3'd4, 0, 2'd0, 0, 0));
        bwrite(mk(1, 0, 2'd0, 3'd4, 0, 2'd0, 0, 0));
        pulse_init();
        chk("R7 init clears CCM phase0", cfg_en, 1'b0);
        bwrite(mk(0, 0, 2'd0, 3'd2, 0, 2'd0, 0, 0));
        bwrite(mk(1, 0, 2'd0, 3'd2, 0, 2'd0, 0, 0));
        pulse_init();
        chk("R7 init ignored CTR", cfg_en, 1'b1);
        // R7 hardware clear beats concurrent write of enable
        bwrite(mk(0, 0, 2'd1, 3'd0, 0, 0, 0, 0));
        bwrite(mk(1, 0, 2'd1, 3'd0, 0, 0, 0, 0));
        @(negedge clk);
        keyprep_done = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = mk(1, 0, 2'd1, 3'd0, 0, 0, 0, 0);
        @(negedge clk);
        keyprep_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        chk("R7 hw clear priority", cfg_en, 1'b0);

        // R8 clear strobes
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0100_0000;
        #1 chk("R8 ccf strobe", {clr_ccf_o, clr_err_o}, 2'b10);
        bus_wdata = 32'h0200_0000;
        #1 chk("R8 err strobe", {clr_ccf_o, clr_err_o}, 2'b01);
        bus_wr = 1'b0;
        #1 chk("R8 no strobe without write", {clr_ccf_o, clr_err_o}, 2'b00);
        bus_sel = 1'b0; bus_wdata = '0;
        bwrite(32'h0300_0000);
        bread(r);
        chk("R8 strobe bits read zero", r, 32'h0);

        // R9 DMA gating sweep
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 4; e++) begin
                bwrite(mk(0, 0, 2'(m), 3'd0, 0, 0, 0, {e[1:0], 2'b00}));
                for (int p = 0; p < 4; p++) begin
                    dma_in_pending  = p[0];
                    dma_out_pending = p[1];
                    #1;
                    chk("R9 dma gate", {dma_in_req, dma_out_req},
                        {p[0] && e[0] && (m == 0 || m == 2),
                         p[1] && e[1] && (m == 0 || m == 2)});
                end
                dma_in_pending = 1'b0; dma_out_pending = 1'b0;
            end
        end

        // R10 interrupt sweep
        for (int v = 0; v < 32; v++) begin
            bwrite(mk(0, 0, 2'd0, 3'd0, 0, 0, 0, {2'b00, v[4], v[3]}));
            flag_ccf = v[0]; flag_rderr = v[1]; flag_wrerr = v[2];
            #1;
            chk("R10 irq", irq_o, (v[0] && v[3]) || ((v[1] || v[2]) && v[4]));
            flag_ccf = 1'b0; flag_rderr = 1'b0; flag_wrerr = 1'b0;
        end

        report();
    end
endmodule